// File: doc/BRIEF.md
# Per-Endpoint Fabric Memory Range Decoder

This block sits at the request entry of a memory device shared by several fabric endpoints. Each incoming request carries a source endpoint number, an address in that endpoint's own host address space and a read/write flag. The block searches a small private table of address ranges that belongs to that endpoint. It then either produces a device-local address or reports an access fault.

Each range entry holds a valid flag, a host base, a length and a device offset. Entries of different endpoints may point at the same device memory, which is how memory is shared. The device memory is also split into 64 MB blocks, and each block is tagged with a group number. Each endpoint holds a mask of the groups it may touch. A block whose group is outside the mask stays hidden even inside a matching range.

Configuration goes through a simple write port that selects the kind of field, the endpoint and an index. Every response appears exactly one clock after its request.

Top module: `fab_range_dec`

## Requirements
- R1: After reset `rsp_valid_o` is low, every range entry is invalid, every block's group is 0 and every endpoint's group mask is empty, so any request faults with cause 1.
- R2: On a hit, `rsp_addr_o` equals the entry's device offset plus (request address minus entry base), modulo 2^DA_W, with `rsp_fault_o` low and `rsp_cause_o` = 0.
- R3: When several valid entries of the same endpoint match, the entry with the lowest index supplies the translation.
- R4: Only the table selected by `req_ep_i` is searched. An address that no valid entry of that table covers faults with `rsp_cause_o` = 1.
- R5: Entries of different endpoints that map onto the same device range translate their requests to identical device addresses.
- R6: An entry covers addresses from its base up to base+size-1 inclusive. base-1 and base+size miss, and a size of 0 never matches.
- R7: The block index is device address bits [DA_W-1:26], the block's group selects one bit of the requesting endpoint's mask, and a clear bit faults the request with `rsp_cause_o` = 2. A range miss (cause 1) takes priority over a group veto, and on any fault `rsp_addr_o` is 0.
- R8: Group filtering works at 64 MB granularity. Two adjacent blocks inside one range are allowed or vetoed independently.
- R9: A request with `req_valid_i` high gives `rsp_valid_o` high on the next clock, and a cycle without a request gives `rsp_valid_o` low on the next clock.
- R10: A configuration write takes effect only for requests presented after the clock edge that performs the write. A request in the same cycle as the write sees the old contents.
- R11: `rsp_we_o` returns the `req_we_i` value of the request being answered.
- R12: Configuration field codes in `cfg_kind_i` are: 0 valid flag (data bit 0), 1 base, 2 size, 3 device offset (entry selected by `cfg_ep_i` and `cfg_idx_i`), 4 block group (block = `cfg_idx_i`, group = low data bits), 5 endpoint group mask (endpoint = `cfg_ep_i`). Clearing a valid flag removes that entry from matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ep_i | input | EP_W | Source endpoint number |
| req_addr_i | input | HA_W | Address in the endpoint's host space |
| req_we_i | input | 1 | 1 = write, 0 = read |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_kind_i | input | 3 | Field selector (see R12) |
| cfg_ep_i | input | EP_W | Endpoint of the configured entry or mask |
| cfg_idx_i | input | IDX_W | Entry index or block index |
| cfg_data_i | input | HA_W | Write data |
| rsp_valid_o | output | 1 | Response present |
| rsp_we_o | output | 1 | Echoed write flag |
| rsp_fault_o | output | 1 | Access fault |
| rsp_cause_o | output | 2 | 0 ok, 1 range miss, 2 group veto |
| rsp_addr_o | output | DA_W | Device-local address, 0 on fault |

## Verification
The hardest case to reach is a request that enters in the same cycle as a configuration write that changes its own outcome. The write must touch exactly the entry or mask that the request depends on. The bench forces this on purpose by lifting a group veto in the same cycle as a request that the veto blocks. The random phase also lets configuration writes and requests overlap freely. Random requests are aimed inside, just below and just past stored ranges, and range bases are drawn from a small set. Because of that, overlapping entries, aliasing across endpoints and block edges inside ranges come up often instead of by chance.

// File: rtl/fab_range_dec_pkg.sv
package fab_range_dec_pkg;
  typedef enum logic [2:0] {
    CFG_VALID  = 3'd0,
    CFG_BASE   = 3'd1,
    CFG_SIZE   = 3'd2,
    CFG_OFFS   = 3'd3,
    CFG_BLKGRP = 3'd4,
    CFG_EPMASK = 3'd5
  } cfg_kind_e;

  typedef enum logic [1:0] {
    CAUSE_OK   = 2'd0,
    CAUSE_MISS = 2'd1,
    CAUSE_VETO = 2'd2
  } cause_e;
endpackage

// File: rtl/ep_range_table.sv
module ep_range_table
  import fab_range_dec_pkg::*;
#(
  parameter int N_EP  = 4,
  parameter int N_ENT = 8,
  parameter int HA_W  = 36,
  parameter int DA_W  = 32,
  localparam int EP_W  = (N_EP > 1) ? $clog2(N_EP) : 1,
  localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [2:0]      wr_kind_i,
  input  logic [EP_W-1:0] wr_ep_i,
  input  logic [ENT_W-1:0] wr_idx_i,
  input  logic [HA_W-1:0] wr_data_i,
  input  logic [EP_W-1:0] rd_ep_i,
  output logic            valid_o [N_ENT],
  output logic [HA_W-1:0] base_o  [N_ENT],
  output logic [HA_W-1:0] size_o  [N_ENT],
  output logic [DA_W-1:0] offs_o  [N_ENT]
);
  logic            valid_q [N_EP][N_ENT];
  logic [HA_W-1:0] base_q  [N_EP][N_ENT];
  logic [HA_W-1:0] size_q  [N_EP][N_ENT];
  logic [DA_W-1:0] offs_q  [N_EP][N_ENT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int e = 0; e < N_EP; e++) begin
        for (int i = 0; i < N_ENT; i++) begin
          valid_q[e][i] <= 1'b0;
          base_q[e][i]  <= '0;
          size_q[e][i]  <= '0;
          offs_q[e][i]  <= '0;
        end
      end
    end else if (wr_en_i) begin
      case (wr_kind_i)
        CFG_VALID: valid_q[wr_ep_i][wr_idx_i] <= wr_data_i[0];
        CFG_BASE:  base_q[wr_ep_i][wr_idx_i]  <= wr_data_i;
        CFG_SIZE:  size_q[wr_ep_i][wr_idx_i]  <= wr_data_i;
        CFG_OFFS:  offs_q[wr_ep_i][wr_idx_i]  <= wr_data_i[DA_W-1:0];
        default: ;
      endcase
    end
  end

  assign valid_o = valid_q[rd_ep_i];
  assign base_o  = base_q[rd_ep_i];
  assign size_o  = size_q[rd_ep_i];
  assign offs_o  = offs_q[rd_ep_i];
endmodule

// File: rtl/range_match.sv
module range_match #(
  parameter int N_ENT = 8,
  parameter int HA_W  = 36,
  parameter int DA_W  = 32
) (
  input  logic [HA_W-1:0] addr_i,
  input  logic            valid_i [N_ENT],
  input  logic [HA_W-1:0] base_i  [N_ENT],
  input  logic [HA_W-1:0] size_i  [N_ENT],
  input  logic [DA_W-1:0] offs_i  [N_ENT],
  output logic            hit_o,
  output logic [DA_W-1:0] dev_addr_o
);
  logic [N_ENT-1:0] match;
  logic [DA_W-1:0]  xlat [N_ENT];

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [HA_W-1:0] diff;
    assign diff     = addr_i - base_i[g];
    assign match[g] = valid_i[g] && (addr_i >= base_i[g]) && (diff < size_i[g]);
    assign xlat[g]  = offs_i[g] + diff[DA_W-1:0];
  end

  // scan from the top so the lowest index is written last and wins
  always_comb begin
    hit_o      = 1'b0;
    dev_addr_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_o      = 1'b1;
        dev_addr_o = xlat[i];
      end
    end
  end
endmodule

// File: rtl/blk_group_map.sv
module blk_group_map
  import fab_range_dec_pkg::*;
#(
  parameter int N_EP  = 4,
  parameter int BLK_W = 6,
  parameter int GRP_W = 3,
  localparam int EP_W  = (N_EP > 1) ? $clog2(N_EP) : 1,
  localparam int N_BLK = 1 << BLK_W,
  localparam int N_GRP = 1 << GRP_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_kind_i,
  input  logic [EP_W-1:0]  wr_ep_i,
  input  logic [BLK_W-1:0] wr_blk_i,
  input  logic [N_GRP-1:0] wr_data_i,
  input  logic [EP_W-1:0]  rd_ep_i,
  input  logic [BLK_W-1:0] rd_blk_i,
  output logic             allow_o
);
  logic [GRP_W-1:0] grp_q  [N_BLK];
  logic [N_GRP-1:0] mask_q [N_EP];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < N_BLK; b++) grp_q[b] <= '0;
      for (int e = 0; e < N_EP; e++)  mask_q[e] <= '0;
    end else if (wr_en_i) begin
      if (wr_kind_i == CFG_BLKGRP) grp_q[wr_blk_i] <= wr_data_i[GRP_W-1:0];
      if (wr_kind_i == CFG_EPMASK) mask_q[wr_ep_i] <= wr_data_i;
    end
  end

  assign allow_o = mask_q[rd_ep_i][grp_q[rd_blk_i]];
endmodule

// File: rtl/fab_range_dec.sv
module fab_range_dec
  import fab_range_dec_pkg::*;
#(
  parameter int N_EP      = 4,
  parameter int N_ENT     = 8,
  parameter int HA_W      = 36,
  parameter int DA_W      = 32,
  parameter int BLK_SHIFT = 26,
  parameter int GRP_W     = 3,
  localparam int EP_W  = (N_EP > 1) ? $clog2(N_EP) : 1,
  localparam int ENT_W = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int BLK_W = DA_W - BLK_SHIFT,
  localparam int N_GRP = 1 << GRP_W,
  localparam int IDX_W = (BLK_W > ENT_W) ? BLK_W : ENT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [EP_W-1:0]  req_ep_i,
  input  logic [HA_W-1:0]  req_addr_i,
  input  logic             req_we_i,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_kind_i,
  input  logic [EP_W-1:0]  cfg_ep_i,
  input  logic [IDX_W-1:0] cfg_idx_i,
  input  logic [HA_W-1:0]  cfg_data_i,
  output logic             rsp_valid_o,
  output logic             rsp_we_o,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_cause_o,
  output logic [DA_W-1:0]  rsp_addr_o
);
  logic            ent_valid [N_ENT];
  logic [HA_W-1:0] ent_base  [N_ENT];
  logic [HA_W-1:0] ent_size  [N_ENT];
  logic [DA_W-1:0] ent_offs  [N_ENT];
  logic            hit;
  logic [DA_W-1:0] dev_addr;
  logic            allow;
  cause_e          cause_d;

  ep_range_table #(
    .N_EP(N_EP), .N_ENT(N_ENT), .HA_W(HA_W), .DA_W(DA_W)
  ) u_table (
    .clk_i, .rst_ni,
    .wr_en_i  (cfg_we_i),
    .wr_kind_i(cfg_kind_i),
    .wr_ep_i  (cfg_ep_i),
    .wr_idx_i (cfg_idx_i[ENT_W-1:0]),
    .wr_data_i(cfg_data_i),
    .rd_ep_i  (req_ep_i),
    .valid_o  (ent_valid),
    .base_o   (ent_base),
    .size_o   (ent_size),
    .offs_o   (ent_offs)
  );

  range_match #(
    .N_ENT(N_ENT), .HA_W(HA_W), .DA_W(DA_W)
  ) u_match (
    .addr_i    (req_addr_i),
    .valid_i   (ent_valid),
    .base_i    (ent_base),
    .size_i    (ent_size),
    .offs_i    (ent_offs),
    .hit_o     (hit),
    .dev_addr_o(dev_addr)
  );

  blk_group_map #(
    .N_EP(N_EP), .BLK_W(BLK_W), .GRP_W(GRP_W)
  ) u_group (
    .clk_i, .rst_ni,
    .wr_en_i  (cfg_we_i),
    .wr_kind_i(cfg_kind_i),
    .wr_ep_i  (cfg_ep_i),
    .wr_blk_i (cfg_idx_i[BLK_W-1:0]),
    .wr_data_i(cfg_data_i[N_GRP-1:0]),
    .rd_ep_i  (req_ep_i),
    .rd_blk_i (dev_addr[DA_W-1:BLK_SHIFT]),
    .allow_o  (allow)
  );

  always_comb begin
    if (!hit)        cause_d = CAUSE_MISS;
    else if (!allow) cause_d = CAUSE_VETO;
    else             cause_d = CAUSE_OK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_we_o    <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_cause_o <= CAUSE_OK;
      rsp_addr_o  <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_we_o    <= req_valid_i && req_we_i;
      rsp_fault_o <= req_valid_i && (cause_d != CAUSE_OK);
      rsp_cause_o <= req_valid_i ? cause_d : CAUSE_OK;
      rsp_addr_o  <= (req_valid_i && cause_d == CAUSE_OK) ? dev_addr : '0;
    end
  end
endmodule

// File: rtl/fab_range_dec_chk.sv
module fab_range_dec_chk #(
  parameter int DA_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_we_i,
  input logic            rsp_valid_o,
  input logic            rsp_we_o,
  input logic            rsp_fault_o,
  input logic [1:0]      rsp_cause_o,
  input logic [DA_W-1:0] rsp_addr_o
);
  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);
  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);
  assert_fault_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_addr_o == '0));
  assert_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_fault_o == (rsp_cause_o != 2'd0)) && (rsp_cause_o != 2'd3));
  assert_we_echo_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> (rsp_we_o == $past(req_we_i)));
endmodule

bind fab_range_dec fab_range_dec_chk #(.DA_W(DA_W)) u_chk (.*);

// File: tb/fab_range_dec_tb.sv
module fab_range_dec_tb;
  localparam int N_EP = 4, N_ENT = 8, HA_W = 36, DA_W = 32, SHIFT = 26;
  localparam int EP_W = 2, IDX_W = 6;

  logic clk = 0, rst_n = 0;
  always #2.5 clk = ~clk;

  logic             req_valid = 0, req_we = 0, cfg_we = 0;
  logic [EP_W-1:0]  req_ep = 0, cfg_ep = 0;
  logic [HA_W-1:0]  req_addr = 0, cfg_data = 0;
  logic [2:0]       cfg_kind = 0;
  logic [IDX_W-1:0] cfg_idx = 0;
  logic             rsp_valid, rsp_we, rsp_fault;
  logic [1:0]       rsp_cause;
  logic [DA_W-1:0]  rsp_addr;

  fab_range_dec u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ep_i(req_ep), .req_addr_i(req_addr), .req_we_i(req_we),
    .cfg_we_i(cfg_we), .cfg_kind_i(cfg_kind), .cfg_ep_i(cfg_ep), .cfg_idx_i(cfg_idx),
    .cfg_data_i(cfg_data),
    .rsp_valid_o(rsp_valid), .rsp_we_o(rsp_we), .rsp_fault_o(rsp_fault),
    .rsp_cause_o(rsp_cause), .rsp_addr_o(rsp_addr)
  );

  // reference model
  bit              m_valid [N_EP][N_ENT];
  logic [HA_W-1:0] m_base  [N_EP][N_ENT];
  logic [HA_W-1:0] m_size  [N_EP][N_ENT];
  logic [DA_W-1:0] m_offs  [N_EP][N_ENT];
  logic [2:0]      m_grp   [64];
  logic [7:0]      m_mask  [N_EP];

  bit              e_valid = 0, e_we = 0;
  logic [1:0]      e_cause = 0;
  logic [DA_W-1:0] e_addr = 0;
  string           e_tag = "R1";
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  function automatic void ref_lookup(input int ep, input logic [HA_W-1:0] a,
                                     output logic [1:0] cause, output logic [DA_W-1:0] da);
    bit hit = 0;
    logic [DA_W-1:0] d = 0;
    for (int i = 0; i < N_ENT; i++) begin
      logic [HA_W-1:0] df = a - m_base[ep][i];
      if (!hit && m_valid[ep][i] && a >= m_base[ep][i] && df < m_size[ep][i]) begin
        hit = 1;
        d = m_offs[ep][i] + df[DA_W-1:0];
      end
    end
    if (!hit) begin cause = 2'd1; da = 0; end
    else if (!m_mask[ep][m_grp[d[DA_W-1:SHIFT]]]) begin cause = 2'd2; da = 0; end
    else begin cause = 2'd0; da = d; end
  endfunction

  task automatic check_prev();
    bit bad;
    n_tests++;
    bad = (rsp_valid !== e_valid);
    if (e_valid)
      bad = bad || (rsp_we !== e_we) || (rsp_cause !== e_cause) ||
            (rsp_fault !== (e_cause != 0)) || (rsp_addr !== e_addr);
    if (bad) begin
      n_fail++;
      $display("FAIL %s: got v=%0b we=%0b f=%0b c=%0d a=%h exp v=%0b we=%0b c=%0d a=%h",
               e_tag, rsp_valid, rsp_we, rsp_fault, rsp_cause, rsp_addr,
               e_valid, e_we, e_cause, e_addr);
    end
  endtask

  task automatic step(input bit rv, input int ep, input logic [HA_W-1:0] a, input bit we,
                      input bit cw, input int kind, input int cep, input int cidx,
                      input logic [HA_W-1:0] cd, input string tag);
    @(negedge clk);
    check_prev();
    req_valid = rv; req_ep = EP_W'(ep); req_addr = a; req_we = we;
    cfg_we = cw; cfg_kind = 3'(kind); cfg_ep = EP_W'(cep); cfg_idx = IDX_W'(cidx); cfg_data = cd;
    e_valid = rv; e_we = we; e_tag = tag;
    if (rv) ref_lookup(ep, a, e_cause, e_addr);
    if (cw) begin
      case (kind)
        0: m_valid[cep][cidx] = cd[0];
        1: m_base[cep][cidx] = cd;
        2: m_size[cep][cidx] = cd;
        3: m_offs[cep][cidx] = cd[DA_W-1:0];
        4: m_grp[cidx] = cd[2:0];
        5: m_mask[cep] = cd[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic req(input int ep, input logic [HA_W-1:0] a, input bit we, input string tag);
    step(1, ep, a, we, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic cfg(input int kind, input int ep, input int idx, input logic [HA_W-1:0] d);
    step(0, 0, 0, 0, 1, kind, ep, idx, d, "R12");
  endtask
  task automatic set_ent(input int ep, input int idx, input logic [HA_W-1:0] b,
                         input logic [HA_W-1:0] s, input logic [HA_W-1:0] o);
    cfg(1, ep, idx, b); cfg(2, ep, idx, s); cfg(3, ep, idx, o); cfg(0, ep, idx, 1);
  endtask

  localparam logic [HA_W-1:0] B0 = 36'h1_0000_0000;

  initial begin
    for (int e = 0; e < N_EP; e++) begin
      m_mask[e] = 0;
      for (int i = 0; i < N_ENT; i++) begin
        m_valid[e][i] = 0; m_base[e][i] = 0; m_size[e][i] = 0; m_offs[e][i] = 0;
      end
    end
    for (int b = 0; b < 64; b++) m_grp[b] = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: idle after reset, then any request misses
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R1");
    req(0, B0, 0, "R1");
    req(3, 36'h0, 1, "R1");
    // R2/R6 single range
    set_ent(0, 0, B0, 36'h800_0000, 36'h0400_0000);
    cfg(5, 0, 0, 36'hFF);
    req(0, B0 + 36'h1234, 0, "R2");
    req(0, B0 + 36'h7FF_FFFF, 1, "R6");
    req(0, B0 + 36'h800_0000, 0, "R6");
    req(0, B0 - 36'h1, 0, "R6");
    set_ent(0, 6, B0, 36'h0, 36'h0);
    req(0, B0 + 36'h900_0000, 0, "R6");
    // R3 overlap
    set_ent(0, 3, B0, 36'h1000_0000, 36'h2000_0000);
    req(0, B0 + 36'h10, 0, "R3");
    req(0, B0 + 36'h900_0000, 1, "R3");
    // R4 other endpoint table is separate
    req(1, B0 + 36'h10, 0, "R4");
    // R5 alias
    set_ent(1, 5, 36'h2_0000_0000, 36'h400_0000, 36'h0400_0000);
    cfg(5, 1, 0, 36'h01);
    req(1, 36'h2_0000_0010, 1, "R5");
    req(0, B0 + 36'h10, 1, "R5");
    // R7 group veto on block 1
    cfg(4, 0, 1, 36'h2);
    cfg(5, 0, 0, 36'hFB);
    req(0, B0 + 36'h10, 0, "R7");
    req(1, 36'h2_0000_0010, 0, "R7");
    req(2, 36'h5, 0, "R7");
    cfg(5, 1, 0, 36'h05);
    req(1, 36'h2_0000_0010, 0, "R7");
    // R8 adjacent blocks
    req(0, B0 + 36'h3FF_FFFF, 0, "R8");
    req(0, B0 + 36'h400_0000, 0, "R8");
    // R10 same-cycle write sees old mask, next request sees new
    step(1, 0, B0 + 36'h20, 1, 1, 5, 0, 0, 36'hFF, "R10");
    req(0, B0 + 36'h20, 1, "R10");
    // R9 back-to-back and idle
    req(2, 36'h7, 1, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R12 clear valid: entry 3 takes over
    cfg(0, 0, 0, 0);
    req(0, B0 + 36'h10, 0, "R12");
    // R11 / random
    for (int n = 0; n < 4000; n++) begin
      int ep = $urandom_range(0, 3);
      int j = $urandom_range(0, 7);
      bit rv = $urandom_range(0, 3) != 0;
      bit cw = $urandom_range(0, 3) == 0;
      int kind = $urandom_range(0, 5);
      logic [HA_W-1:0] cd;
      logic [HA_W-1:0] a;
      case (kind)
        0: cd = HA_W'($urandom_range(0, 3) != 0);
        1: cd = HA_W'($urandom_range(0, 63)) << 26;
        2: cd = HA_W'($urandom_range(0, 32'h0C00_0000));
        3: cd = HA_W'($urandom);
        4: cd = HA_W'($urandom_range(0, 7));
        default: cd = HA_W'($urandom_range(0, 255));
      endcase
      a = m_base[ep][j] + HA_W'($urandom_range(0, 32'h0C00_0010)) - 36'h8;
      step(rv, ep, a, $urandom_range(0, 1) == 1, cw, kind, $urandom_range(0, 3),
           (kind == 4) ? $urandom_range(0, 63) : $urandom_range(0, 7), cd, "R11");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #500000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got running expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule